// File: doc/BRIEF.md
# Sequential Signed/Unsigned Integer Multiplier

This block multiplies an accumulator operand by a source operand for a small processor datapath. A size input picks between a byte form and a word form. In byte form the low 8 bits of each operand are multiplied and the 16-bit product comes back on the low result word. In word form the full 16-bit operands are multiplied and the 32-bit product comes back as an upper word and a lower word. A mode input picks either unsigned arithmetic or two's-complement signed arithmetic.

A single carry/overflow flag comes back with each product. In unsigned mode the flag is set when the upper half of the product is non-zero. In signed mode it is set when the upper half is anything other than copies of the sign bit of the lower half. So in both modes a clear flag means the whole result fits in the lower half of the destination. The datapath is a multi-cycle shift-add engine that works on operand magnitudes. In signed mode it negates the finished product when the operand signs differ. A one-cycle start pulse begins an operation. A one-cycle done pulse marks the cycle from which the product and flag are valid, and they hold until the next done.

Top module: `mul_unit`

## Requirements
- R1: In word form (word_size=1) with signed_mode=0, {prod_hi, prod_lo} equals the unsigned 32-bit product of acc_in and src_in. For example, 0xFFFF times 0xFFFF gives 0xFFFE0001.
- R2: In byte form (word_size=0), prod_lo carries the 16-bit product of acc_in[7:0] and src_in[7:0], and prod_hi is 0x0000. Bits 15:8 of both operands have no effect on any output.
- R3: With signed_mode=1, both operands are two's-complement values of the selected width and the product is two's-complement. For example, 0xFFFF times 0xFFFF gives 0x00000001 and 0xFFFF times 0x0100 gives 0xFFFFFF00.
- R4: With signed_mode=0, cf_of is 1 exactly when the upper half of the product is non-zero. In word form the upper half is prod_hi; in byte form it is prod_lo[15:8].
- R5: With signed_mode=1, cf_of is 0 exactly when every bit of the upper half equals the sign bit of the lower half, and 1 otherwise. In word form that compares prod_hi with prod_lo[15]; in byte form it compares prod_lo[15:8] with prod_lo[7].
- R6: done is high for exactly one cycle. It rises on the 9th rising edge after the edge that accepts start in byte form, and on the 17th in word form. busy is high from the accepting edge until done rises.
- R7: A start pulse that arrives while busy is high is ignored. The running operation completes with its own operands and mode, and no extra done follows.
- R8: While rst_n is low at a clock edge, the block returns to idle: busy=0, done=0, prod_hi=0, prod_lo=0, cf_of=0.
- R9: prod_hi, prod_lo and cf_of change only on the edge that raises done. Input changes made without an accepted start leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation; accepted only while idle |
| signed_mode | input | 1 | 1 = two's-complement signed, 0 = unsigned |
| word_size | input | 1 | 1 = 16x16 word form, 0 = 8x8 byte form |
| acc_in | input | 16 | Accumulator operand (low byte only in byte form) |
| src_in | input | 16 | Source operand (low byte only in byte form) |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: results valid from this cycle |
| prod_hi | output | 16 | Upper product word (zero in byte form) |
| prod_lo | output | 16 | Lower product word, or the full byte-form product |
| cf_of | output | 1 | Combined carry/overflow flag |

## Verification
A broken shift-add step, a miscounted iteration or a dropped sign correction does not surface until the done edge, and then it surfaces as a wrong product or flag. The sweep across every accumulator byte in both modes, plus word-form corner values around 0x7FFF, 0x8000 and 0xFFFF, exposes such errors on the first affected operation. A wrong iteration count, or a control state that mishandles a second start, shows up as done arriving off the 9- or 17-edge mark, as a second done, or as result words that move outside a done cycle. The bench checks each of these at every operation.

// File: rtl/mul_pkg.sv
// Package: types shared by the multiplier modules.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package mul_pkg;

    // Control sequence of the multiplier: wait, iterate, finalise.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mul_state_t;

endpackage

// File: rtl/mul_operand_prep.sv
// Module: mul_operand_prep
// Turns raw operands into unsigned magnitudes of the selected width and works
// out whether the final product has to be negated.
// Assumes: W is even; byte form uses the low W/2 bits of each operand.
module mul_operand_prep #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_raw,
    input  logic [W-1:0] b_raw,
    input  logic         signed_mode,
    input  logic         word_size,
    output logic [W-1:0] a_mag,
    output logic [W-1:0] b_mag,
    output logic         negate
);
    localparam int HW = W / 2;

    logic [W-1:0] a_sel;
    logic [W-1:0] b_sel;
    logic         a_neg;
    logic         b_neg;

    // Pick operand width and zero-extend the byte form.
    always_comb begin
        if (word_size) begin
            a_sel = a_raw;
            b_sel = b_raw;
            a_neg = signed_mode & a_raw[W-1];
            b_neg = signed_mode & b_raw[W-1];
        end else begin
            a_sel = {{HW{1'b0}}, a_raw[HW-1:0]};
            b_sel = {{HW{1'b0}}, b_raw[HW-1:0]};
            a_neg = signed_mode & a_raw[HW-1];
            b_neg = signed_mode & b_raw[HW-1];
        end
    end

    // Take magnitudes; the most negative value maps to 2^(n-1), which still fits.
    always_comb begin
        a_mag = a_sel;
        b_mag = b_sel;
        if (a_neg) begin
            a_mag = word_size ? (~a_sel + 1'b1)
                              : {{HW{1'b0}}, (~a_sel[HW-1:0] + 1'b1)};
        end
        if (b_neg) begin
            b_mag = word_size ? (~b_sel + 1'b1)
                              : {{HW{1'b0}}, (~b_sel[HW-1:0] + 1'b1)};
        end
        negate = a_neg ^ b_neg;
    end

endmodule

// File: rtl/mul_shift_add_core.sv
// Module: mul_shift_add_core
// Iterative unsigned shift-add multiplier: each cycle handles one multiplier
// bit. A load sets the iteration count; last flags the final step.
// Assumes: iter_count <= W; load and step never coincide with another load.
module mul_shift_add_core #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  mcand_in,
    input  logic [W-1:0]  mplier_in,
    input  logic [CW-1:0] iter_count,
    output logic [2*W-1:0] raw_prod,
    output logic          last
);
    logic [2*W-1:0] mcand_sh;
    logic [W-1:0]   mplier_sh;
    logic [2*W-1:0] acc;
    logic [CW-1:0]  cnt;

    // Load operands or perform one add-and-shift step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_sh  <= '0;
            mplier_sh <= '0;
            acc       <= '0;
            cnt       <= '0;
        end else if (load) begin
            mcand_sh  <= {{W{1'b0}}, mcand_in};
            mplier_sh <= mplier_in;
            acc       <= '0;
            cnt       <= iter_count;
        end else if (cnt != '0) begin
            if (mplier_sh[0]) begin
                acc <= acc + mcand_sh;
            end
            mcand_sh  <= mcand_sh << 1;
            mplier_sh <= mplier_sh >> 1;
            cnt       <= cnt - 1'b1;
        end
    end

    assign raw_prod = acc;
    assign last     = (cnt == CW'(1));

    // R6: the iteration counter never exceeds the word width.
    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(W));

endmodule

// File: rtl/mul_result_fix.sv
// Module: mul_result_fix
// Applies the sign correction to the magnitude product, splits it into
// result words and derives the carry/overflow flag for the active mode.
// Assumes: raw_prod is the complete magnitude product of the selected width.
module mul_result_fix #(
    parameter int W = 16
) (
    input  logic [2*W-1:0] raw_prod,
    input  logic           negate,
    input  logic           signed_mode,
    input  logic           word_size,
    output logic [W-1:0]   res_hi,
    output logic [W-1:0]   res_lo,
    output logic           flag
);
    localparam int HW = W / 2;

    logic [2*W-1:0] full;

    // Two's-complement correction of the whole product.
    always_comb begin
        full = negate ? (~raw_prod + {{(2*W-1){1'b0}}, 1'b1}) : raw_prod;
    end

    // Split into words and evaluate the fit-in-lower-half test.
    always_comb begin
        if (word_size) begin
            res_hi = full[2*W-1:W];
            res_lo = full[W-1:0];
            if (signed_mode) begin
                flag = (full[2*W-1:W] != {W{full[W-1]}});
            end else begin
                flag = (full[2*W-1:W] != '0);
            end
        end else begin
            res_hi = '0;
            res_lo = full[W-1:0];
            if (signed_mode) begin
                flag = (full[W-1:HW] != {HW{full[HW-1]}});
            end else begin
                flag = (full[W-1:HW] != '0);
            end
        end
    end

endmodule

// File: rtl/mul_unit.sv
// Module: mul_unit (top)
// Byte/word, signed/unsigned multiplier with a start/done handshake and a
// combined carry/overflow flag. Mode and size are captured at start.
// Assumes: start is ignored while busy; results hold between done pulses.
module mul_unit
    import mul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         signed_mode,
    input  logic         word_size,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] src_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] prod_lo,
    output logic         cf_of
);
    localparam int HW = W / 2;
    localparam int CW = $clog2(W + 1);

    mul_state_t     state;
    logic           signed_q;
    logic           word_q;
    logic           neg_q;
    logic           accept;
    logic [W-1:0]   a_mag;
    logic [W-1:0]   b_mag;
    logic           neg_d;
    logic [CW-1:0]  iters;
    logic [2*W-1:0] raw_prod;
    logic           last;
    logic [W-1:0]   fix_hi;
    logic [W-1:0]   fix_lo;
    logic           fix_flag;

    assign accept = (state == ST_IDLE) && start;
    assign iters  = word_size ? CW'(W) : CW'(HW);
    assign busy   = (state != ST_IDLE);

    mul_operand_prep #(.W(W)) u_prep (
        .a_raw       (acc_in),
        .b_raw       (src_in),
        .signed_mode (signed_mode),
        .word_size   (word_size),
        .a_mag       (a_mag),
        .b_mag       (b_mag),
        .negate      (neg_d)
    );

    mul_shift_add_core #(.W(W), .CW(CW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .mcand_in   (a_mag),
        .mplier_in  (b_mag),
        .iter_count (iters),
        .raw_prod   (raw_prod),
        .last       (last)
    );

    mul_result_fix #(.W(W)) u_fix (
        .raw_prod    (raw_prod),
        .negate      (neg_q),
        .signed_mode (signed_q),
        .word_size   (word_q),
        .res_hi      (fix_hi),
        .res_lo      (fix_lo),
        .flag        (fix_flag)
    );

    // Control sequence and capture of mode, size and sign correction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            signed_q <= 1'b0;
            word_q   <= 1'b0;
            neg_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_RUN;
                        signed_q <= signed_mode;
                        word_q   <= word_size;
                        neg_q    <= neg_d;
                    end
                end
                ST_RUN: begin
                    if (last) begin
                        state <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Result registers and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            prod_hi <= '0;
            prod_lo <= '0;
            cf_of   <= 1'b0;
        end else begin
            done <= (state == ST_FIN);
            if (state == ST_FIN) begin
                prod_hi <= fix_hi;
                prod_lo <= fix_lo;
                cf_of   <= fix_flag;
            end
        end
    end

    // R6: done lasts a single cycle.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done only follows a busy cycle.
    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R7: captured mode and size stay fixed while an operation runs.
    assert_mode_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> ($stable(signed_q) && $stable(word_q) && $stable(neg_q)));

    // R9: result outputs move only on the done edge.
    assert_hold_results_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(prod_hi) && $stable(prod_lo) && $stable(cf_of)));

    // R2: byte form never drives the upper word.
    assert_byte_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !word_q) |-> (prod_hi == '0));

    // R4: unsigned word-form flag agrees with the upper word.
    assert_uflag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && word_q && !signed_q) |-> (cf_of == (prod_hi != '0)));

    // R5: signed word-form flag agrees with the sign-extension test.
    assert_sflag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && word_q && signed_q) |-> (cf_of == (prod_hi != {W{prod_lo[W-1]}})));

endmodule

// File: tb/mul_unit_test.sv
// Bench: byte-form sweep in both modes, word-form corner grid, worked
// examples, handshake timing, ignored start and result hold.
module mul_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic        word_size = 1'b0;
    logic [15:0] acc_in = '0;
    logic [15:0] src_in = '0;
    logic        busy;
    logic        done;
    logic [15:0] prod_hi;
    logic [15:0] prod_lo;
    logic        cf_of;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mul_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .word_size(word_size), .acc_in(acc_in), .src_in(src_in),
        .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo), .cf_of(cf_of)
    );

    // Watchdog: counts as a failed check and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual cycles=%0d expected below 190000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Arithmetic model of the requirements.
    task automatic model(input bit sg, input bit wd, input logic [15:0] a, input logic [15:0] b,
                         output logic [15:0] ehi, output logic [15:0] elo, output bit ef);
        longint ea, eb, p;
        if (wd) begin
            ea = sg ? longint'($signed(a)) : longint'(a);
            eb = sg ? longint'($signed(b)) : longint'(b);
        end else begin
            ea = sg ? longint'($signed(a[7:0])) : longint'(a[7:0]);
            eb = sg ? longint'($signed(b[7:0])) : longint'(b[7:0]);
        end
        p = ea * eb;
        if (wd) begin
            ehi = p[31:16];
            elo = p[15:0];
            ef  = sg ? (p < -32768 || p > 32767) : (p > 65535);
        end else begin
            ehi = 16'h0000;
            elo = p[15:0];
            ef  = sg ? (p < -128 || p > 127) : (p > 255);
        end
    endtask

    // One operation: drive at negedge, count edges to done, compare.
    task automatic run_op(input bit sg, input bit wd, input logic [15:0] a, input logic [15:0] b,
                          input string req);
        logic [15:0] ehi, elo;
        bit ef;
        int n;
        model(sg, wd, a, b, ehi, elo, ef);
        @(negedge clk);
        signed_mode = sg; word_size = wd; acc_in = a; src_in = b; start = 1'b1;
        n = 0;
        while (1) begin
            @(negedge clk);
            start = 1'b0;
            n++;
            if (done || n > 40) break;
        end
        chk(n - 1 == (wd ? 17 : 9), "R6 latency", 64'(n - 1), 64'(wd ? 17 : 9));
        chk({prod_hi, prod_lo} == {ehi, elo}, req, {32'h0, prod_hi, prod_lo}, {32'h0, ehi, elo});
        chk(cf_of == ef, sg ? "R5 flag" : "R4 flag", 64'(cf_of), 64'(ef));
        @(negedge clk);
        chk(!done && !busy, "R6 single pulse", {62'h0, done, busy}, 64'h0);
    endtask

    initial begin
        logic [15:0] hold_hi, hold_lo;
        logic        hold_f;
        logic [15:0] wv [10] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000,
                                 16'hFFFF, 16'h0FFF, 16'h0100, 16'h1234, 16'hFF06};
        int extra;

        // R8: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && prod_hi == 0 && prod_lo == 0 && !cf_of, "R8 reset",
            {29'h0, busy, done, cf_of, prod_hi, prod_lo}, 64'h0);
        rst_n = 1'b1;

        // Worked examples (R1, R3, R4, R5)
        run_op(1'b0, 1'b1, 16'hFFFF, 16'hFFFF, "R1 ffff*ffff");
        run_op(1'b1, 1'b1, 16'hFFFF, 16'hFFFF, "R3 ffff*ffff");
        run_op(1'b0, 1'b1, 16'h0001, 16'hFFFF, "R1 0001*ffff");
        run_op(1'b1, 1'b1, 16'h0001, 16'hFFFF, "R3 0001*ffff");
        run_op(1'b0, 1'b1, 16'h0FFF, 16'h0100, "R1 0fff*0100");
        run_op(1'b1, 1'b1, 16'hFFFF, 16'h0100, "R3 ffff*0100");
        run_op(1'b0, 1'b1, 16'h0FFF, 16'h0FFF, "R1 0fff*0fff");
        run_op(1'b1, 1'b1, 16'h0FFF, 16'h0FFF, "R3 0fff*0fff");

        // Word-form corner grid in both modes
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    run_op(s[0], 1'b1, wv[i], wv[j], s == 0 ? "R1 word grid" : "R3 word grid");

        // R2: byte sweep; upper operand bytes carry junk that must not matter
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b += 17)
                    run_op(s[0], 1'b0, {8'(a * 37 + 5), 8'(a)}, {8'(b ^ 8'h5A), 8'(b)},
                           s == 0 ? "R2 byte unsigned" : "R2 byte signed");

        // R7: start while busy is ignored
        @(negedge clk);
        signed_mode = 1'b0; word_size = 1'b1; acc_in = 16'h1234; src_in = 16'h0100; start = 1'b1;
        @(negedge clk);
        signed_mode = 1'b1; word_size = 1'b0; acc_in = 16'hFFFF; src_in = 16'hFFFF;
        repeat (5) @(negedge clk);
        start = 1'b0;
        extra = 0;
        while (!done && extra < 40) begin
            @(negedge clk);
            extra++;
        end
        chk({prod_hi, prod_lo} == 32'h00123400, "R7 first operands kept",
            {32'h0, prod_hi, prod_lo}, 64'h00123400);
        chk(cf_of == 1'b1, "R7 flag of first op", 64'(cf_of), 64'h1);
        extra = 0;
        repeat (25) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk(extra == 0, "R7 no extra done", 64'(extra), 64'h0);

        // R9: results hold while inputs change without start
        hold_hi = prod_hi; hold_lo = prod_lo; hold_f = cf_of;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            acc_in = 16'(k * 4099); src_in = 16'(k * 771); signed_mode = k[0]; word_size = k[1];
        end
        @(negedge clk);
        chk({prod_hi, prod_lo, cf_of} == {hold_hi, hold_lo, hold_f}, "R9 hold",
            {31'h0, prod_hi, prod_lo, cf_of}, {31'h0, hold_hi, hold_lo, hold_f});

        // R8: reset mid-operation returns to idle
        @(negedge clk);
        word_size = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !done && prod_hi == 0 && prod_lo == 0 && !cf_of, "R8 reset mid-run",
            {29'h0, busy, done, cf_of, prod_hi, prod_lo}, 64'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule